// File: doc/BRIEF.md
# Serial DMA Pointer and Interrupt Status Controller

This block keeps the transmit and receive DMA address pointers for one serial communication port and drives four sticky status flags for them. Each accepted byte transfer moves the active pointer forward by one. The block watches the pointer for half-page and full-page wraps, stops a direction on its terminal events, and records transmit errors reported by outside logic. Software clears flags by writing zeros through a masked register write port. A written one never sets or clears anything. A set terminal flag holds its direction stopped, so clearing the flag lets the DMA continue if its enable is still on.

Pages are 4 KB. A full-page event is an increment that leaves the low 12 pointer bits at zero. A half-page event is an increment that leaves the low 11 bits at zero. Pointers may be reloaded only while their direction is stopped. A combined interrupt line reports any flag that its mask bit lets through.

Top module: `dma_stat_ctrl`

## Requirements
- R1: During and after reset both pointers are zero, all four status flags are zero and `irq_o` is low.
- R2: Transmit runs (`tx_run_o`=1) when `tx_en_i` is 1 and status bits 3 and 2 are both 0. Each cycle with `tx_byte_i`=1, transmit running and no error input raised adds one to `tx_ptr_o`. While transmit is not running the pointer does not move.
- R3: A transmit increment that leaves the low 12 bits of `tx_ptr_o` at zero sets status bit 3 (transmit page) and stops transmit.
- R4: If any bit of `tx_err_i` is 1 while transmit runs, status bit 2 (transmit error) is set and transmit stops. `tx_ptr_o` keeps its value in that cycle, even with `tx_byte_i`=1.
- R5: Receive runs (`rx_run_o`=1) when `rx_en_i` is 1 and status bit 0 is 0. Each cycle with `rx_byte_i`=1 while receive runs adds one to `rx_ptr_o`. An increment that leaves the low 11 bits at zero sets status bit 1 (receive half page) and does not stop receive.
- R6: A receive increment that leaves the low 12 bits at zero sets status bit 0 (receive page) and status bit 1 together, and stops receive.
- R7: A cycle with `wr_en_i`=1 clears each status bit whose `wr_mask_i` bit is 1 and whose `wr_data_i` bit is 0. Bits with data 1 or mask 0 keep their value. Clearing a terminal flag restarts its direction if its enable is still 1.
- R8: If a hardware set event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `ptr_ld_i` writes `ptr_ld_val_i` into the transmit pointer (`ptr_ld_sel_i`=0) or the receive pointer (`ptr_ld_sel_i`=1) only while that direction is not running. Otherwise the load is ignored. A load never changes a status bit.
- R10: `irq_o` is 1 exactly when some status bit and the same bit of `irq_mask_i` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmit DMA enable |
| rx_en_i | input | 1 | Receive DMA enable |
| tx_byte_i | input | 1 | One transmit byte moved this cycle |
| rx_byte_i | input | 1 | One receive byte moved this cycle |
| tx_err_i | input | 3 | Transmit error reports: parity, page crossing, length limit |
| ptr_ld_i | input | 1 | Pointer load request |
| ptr_ld_sel_i | input | 1 | Load target: 0 transmit, 1 receive |
| ptr_ld_val_i | input | PTR_W | Pointer value to load |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 4 | Status write data; a zero clears |
| wr_mask_i | input | 4 | Bits taking part in the write |
| irq_mask_i | input | 4 | Interrupt mask per status bit |
| tx_ptr_o | output | PTR_W | Transmit pointer |
| rx_ptr_o | output | PTR_W | Receive pointer |
| tx_run_o | output | 1 | Transmit DMA active |
| rx_run_o | output | 1 | Receive DMA active |
| status_o | output | 4 | Flags: 3 tx page, 2 tx error, 1 rx half, 0 rx page |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach is a hardware set landing in the same cycle as a software clear of the same flag. It needs a running direction whose pointer sits one byte short of a boundary, at the moment a masked write of zero arrives. The stimulus gets there with directed loads placed just below the half and full boundaries. The random phase also draws load values from the last few addresses before a boundary, so wraps, clears and restarts overlap often.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

    localparam int FLAG_N = 4;

    typedef struct packed {
        logic tx_page;
        logic tx_err;
        logic rx_half;
        logic rx_page;
    } dsc_flags_t;

    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;
    localparam int DIR_N  = 2;

endpackage

// File: rtl/dsc_ptr_unit.sv
module dsc_ptr_unit #(
    parameter int PTR_W     = 16,
    parameter int PAGE_BITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             step_i,
    input  logic             freeze_i,
    input  logic             ld_i,
    input  logic [PTR_W-1:0] ld_val_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [1:0]       evt_o
);
    localparam int HALF_BITS = PAGE_BITS - 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t       st_d, st_q;
    logic [PTR_W-1:0] nxt;
    logic             adv;

    always_comb begin
        st_d  = st_q;
        adv   = run_i && step_i && !freeze_i;
        nxt   = st_q.ptr + PTR_W'(1);
        evt_o = 2'b00;
        if (adv) begin
            st_d.ptr = nxt;
            evt_o[0] = (nxt[HALF_BITS-1:0] == '0);
            evt_o[1] = (nxt[PAGE_BITS-1:0] == '0);
        end else if (ld_i && !run_i) begin
            st_d.ptr = ld_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;

endmodule

// File: rtl/dsc_status_reg.sv
module dsc_status_reg
    import dma_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [FLAG_N-1:0] wr_data_i,
    input  logic [FLAG_N-1:0] wr_mask_i,
    input  dsc_flags_t        set_i,
    output dsc_flags_t        flags_o
);
    typedef struct packed {
        dsc_flags_t flags;
    } stat_state_t;

    stat_state_t       st_d, st_q;
    logic [FLAG_N-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = wr_en_i ? (wr_mask_i & ~wr_data_i) : '0;
        st_d.flags = dsc_flags_t'((st_q.flags & ~clr) | set_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/dma_stat_ctrl.sv
module dma_stat_ctrl
    import dma_stat_pkg::*;
#(
    parameter int PTR_W     = 16,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en_i,
    input  logic              rx_en_i,
    input  logic              tx_byte_i,
    input  logic              rx_byte_i,
    input  logic [2:0]        tx_err_i,
    input  logic              ptr_ld_i,
    input  logic              ptr_ld_sel_i,
    input  logic [PTR_W-1:0]  ptr_ld_val_i,
    input  logic              wr_en_i,
    input  logic [FLAG_N-1:0] wr_data_i,
    input  logic [FLAG_N-1:0] wr_mask_i,
    input  logic [FLAG_N-1:0] irq_mask_i,
    output logic [PTR_W-1:0]  tx_ptr_o,
    output logic [PTR_W-1:0]  rx_ptr_o,
    output logic              tx_run_o,
    output logic              rx_run_o,
    output logic [FLAG_N-1:0] status_o,
    output logic              irq_o
);
    dsc_flags_t       flags;
    dsc_flags_t       set_ev;
    logic             err_any;
    logic             run    [DIR_N];
    logic             step   [DIR_N];
    logic             freeze [DIR_N];
    logic             ld     [DIR_N];
    logic [PTR_W-1:0] ptr    [DIR_N];
    logic [1:0]       evt    [DIR_N];

    always_comb begin
        err_any      = |tx_err_i;
        run[DIR_TX]  = tx_en_i && !flags.tx_page && !flags.tx_err;
        run[DIR_RX]  = rx_en_i && !flags.rx_page;
        step[DIR_TX] = tx_byte_i;
        step[DIR_RX] = rx_byte_i;
        freeze[DIR_TX] = err_any;
        freeze[DIR_RX] = 1'b0;
        ld[DIR_TX]   = ptr_ld_i && !ptr_ld_sel_i;
        ld[DIR_RX]   = ptr_ld_i && ptr_ld_sel_i;
    end

    for (genvar g = 0; g < DIR_N; g++) begin : g_dir
        dsc_ptr_unit #(
            .PTR_W     (PTR_W),
            .PAGE_BITS (PAGE_BITS)
        ) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_i    (run[g]),
            .step_i   (step[g]),
            .freeze_i (freeze[g]),
            .ld_i     (ld[g]),
            .ld_val_i (ptr_ld_val_i),
            .ptr_o    (ptr[g]),
            .evt_o    (evt[g])
        );
    end

    always_comb begin
        set_ev         = '0;
        set_ev.tx_page = evt[DIR_TX][1] && evt[DIR_TX][0];
        set_ev.tx_err  = run[DIR_TX] && err_any;
        set_ev.rx_half = evt[DIR_RX][0];
        set_ev.rx_page = evt[DIR_RX][1];
    end

    dsc_status_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .wr_mask_i (wr_mask_i),
        .set_i     (set_ev),
        .flags_o   (flags)
    );

    always_comb begin
        tx_ptr_o = ptr[DIR_TX];
        rx_ptr_o = ptr[DIR_RX];
        tx_run_o = run[DIR_TX];
        rx_run_o = run[DIR_RX];
        status_o = flags;
        irq_o    = |(flags & irq_mask_i);
    end

endmodule

module dma_stat_ctrl_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en_i,
    input logic             rx_en_i,
    input logic             tx_byte_i,
    input logic             rx_byte_i,
    input logic [2:0]       tx_err_i,
    input logic             ptr_ld_i,
    input logic             ptr_ld_sel_i,
    input logic             wr_en_i,
    input logic [3:0]       wr_data_i,
    input logic [3:0]       wr_mask_i,
    input logic [3:0]       irq_mask_i,
    input logic [PTR_W-1:0] tx_ptr_o,
    input logic [PTR_W-1:0] rx_ptr_o,
    input logic             tx_run_o,
    input logic             rx_run_o,
    input logic [3:0]       status_o,
    input logic             irq_o
);
    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_run_o && !(ptr_ld_i && !ptr_ld_sel_i)) |=> $stable(tx_ptr_o));

    // R4
    tx_err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_run_o && (|tx_err_i)) |=> (status_o[2] && !tx_run_o && $stable(tx_ptr_o)));

    // R5
    rx_half_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status_o[1]) && !status_o[0] && rx_en_i) |-> rx_run_o);

    // R6
    rx_page_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> (status_o[1] && !rx_run_o));

    // R6
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_run_o && !(ptr_ld_i && ptr_ld_sel_i) && rx_byte_i) |=> $stable(rx_ptr_o));

    // R9
    tx_ld_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_ld_i && !ptr_ld_sel_i && tx_run_o && !tx_byte_i && tx_en_i)
        |=> $stable(tx_ptr_o));

    // R10
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(status_o & irq_mask_i)));

    for (genvar b = 0; b < 4; b++) begin : g_bit
        // R7
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[b] && !(wr_en_i && wr_mask_i[b] && !wr_data_i[b])) |=> status_o[b]);
    end

endmodule

bind dma_stat_ctrl dma_stat_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en_i      (tx_en_i),
    .rx_en_i      (rx_en_i),
    .tx_byte_i    (tx_byte_i),
    .rx_byte_i    (rx_byte_i),
    .tx_err_i     (tx_err_i),
    .ptr_ld_i     (ptr_ld_i),
    .ptr_ld_sel_i (ptr_ld_sel_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .wr_mask_i    (wr_mask_i),
    .irq_mask_i   (irq_mask_i),
    .tx_ptr_o     (tx_ptr_o),
    .rx_ptr_o     (rx_ptr_o),
    .tx_run_o     (tx_run_o),
    .rx_run_o     (rx_run_o),
    .status_o     (status_o),
    .irq_o        (irq_o)
);

// File: tb/dma_stat_ctrl_bench.sv
module dma_stat_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int PW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 0, rx_en = 0, tx_byte = 0, rx_byte = 0;
    logic [2:0]    tx_err = '0;
    logic          ld = 0, ld_sel = 0;
    logic [PW-1:0] ld_val = '0;
    logic          wr_en = 0;
    logic [3:0]    wr_data = '0, wr_mask = '0, irq_mask = '0;
    logic [PW-1:0] tx_ptr, rx_ptr;
    logic          tx_run, rx_run, irq;
    logic [3:0]    status;

    logic [PW-1:0] e_tx = '0, e_rx = '0;
    logic [3:0]    e_st = '0;
    int            n_chk = 0, n_fail = 0;
    bit            done = 0;

    always #(CLK_P/2) clk = ~clk;

    dma_stat_ctrl u_dma_stat_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .rx_en_i(rx_en),
        .tx_byte_i(tx_byte), .rx_byte_i(rx_byte), .tx_err_i(tx_err),
        .ptr_ld_i(ld), .ptr_ld_sel_i(ld_sel), .ptr_ld_val_i(ld_val),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_mask_i(wr_mask),
        .irq_mask_i(irq_mask), .tx_ptr_o(tx_ptr), .rx_ptr_o(rx_ptr),
        .tx_run_o(tx_run), .rx_run_o(rx_run), .status_o(status), .irq_o(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit f_trun(logic [3:0] st);
        return tx_en && !st[3] && !st[2];
    endfunction

    function automatic bit f_rrun(logic [3:0] st);
        return rx_en && !st[0];
    endfunction

    // Advance the expected state by one clock from the current inputs.
    task automatic model();
        logic [3:0]    n_st = e_st;
        logic [PW-1:0] p;
        bit            tr = f_trun(e_st);
        bit            rr = f_rrun(e_st);
        if (wr_en) n_st = n_st & ~(wr_mask & ~wr_data);
        if (tr && (tx_err != 0)) n_st[2] = 1'b1;
        else if (tr && tx_byte) begin
            p = e_tx + 1'b1;
            if (p[11:0] == 0) n_st[3] = 1'b1;
            e_tx = p;
        end
        if (ld && !ld_sel && !tr) e_tx = ld_val;
        if (rr && rx_byte) begin
            p = e_rx + 1'b1;
            if (p[10:0] == 0) n_st[1] = 1'b1;
            if (p[11:0] == 0) n_st[0] = 1'b1;
            e_rx = p;
        end
        if (ld && ld_sel && !rr) e_rx = ld_val;
        e_st = n_st;
    endtask

    task automatic cycle();
        model();
        @(posedge clk);
        #(CLK_P/4);
        check("R2 tx_ptr", 32'(tx_ptr), 32'(e_tx));
        check("R5 rx_ptr", 32'(rx_ptr), 32'(e_rx));
        check("R7 status", 32'(status), 32'(e_st));
        check("R2 tx_run", 32'(tx_run), 32'(f_trun(e_st)));
        check("R6 rx_run", 32'(rx_run), 32'(f_rrun(e_st)));
        check("R10 irq", 32'(irq), 32'(|(e_st & irq_mask)));
        @(negedge clk);
    endtask

    task automatic idle();
        tx_byte = 0; rx_byte = 0; tx_err = '0; ld = 0; wr_en = 0;
    endtask

    task automatic load(bit sel, logic [PW-1:0] v);
        idle(); ld = 1; ld_sel = sel; ld_val = v; cycle(); ld = 0;
    endtask

    task automatic wr(logic [3:0] d, logic [3:0] m);
        idle(); wr_en = 1; wr_data = d; wr_mask = m; cycle(); wr_en = 0;
    endtask

    function automatic logic [PW-1:0] near_edge();
        logic [PW-1:0] v = PW'($urandom);
        case ($urandom % 4)
            0: v[11:0] = 12'hFF8 + 12'($urandom % 8);
            1: v[11:0] = 12'h7F8 + 12'($urandom % 8);
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        void'($urandom(32'h0005_EED1));
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        // R1 reset state
        check("R1 tx_ptr", 32'(tx_ptr), 0);
        check("R1 rx_ptr", 32'(rx_ptr), 0);
        check("R1 status", 32'(status), 0);
        check("R1 irq", 32'(irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_mask = 4'hF;

        // R3 transmit page wrap stops transmit
        load(0, 16'h0FFE);
        tx_en = 1; tx_byte = 1;
        cycle(); cycle();
        check("R3 tx_ptr wrap", 32'(tx_ptr), 32'h1000);
        check("R3 tx page bit", 32'(status), 32'h8);
        check("R3 tx stopped", 32'(tx_run), 0);
        cycle();
        check("R2 no move while stopped", 32'(tx_ptr), 32'h1000);

        // R7 written one keeps bit, written zero clears and restarts
        wr(4'hF, 4'h8);
        check("R7 write one keeps", 32'(status), 32'h8);
        wr(4'h0, 4'h8);
        check("R7 write zero clears", 32'(status), 32'h0);
        check("R7 restart", 32'(tx_run), 1);

        // R4 error freezes pointer and stops
        idle(); tx_byte = 1; tx_err = 3'b010; cycle(); idle();
        check("R4 err bit", 32'(status), 32'h4);
        check("R4 ptr kept", 32'(tx_ptr), 32'h1000);
        check("R4 stopped", 32'(tx_run), 0);

        // R9 load while stopped works and keeps status
        load(0, 16'h2345);
        check("R9 load stopped", 32'(tx_ptr), 32'h2345);
        check("R9 status kept", 32'(status), 32'h4);
        wr(4'h0, 4'h4);
        load(0, 16'h0111);
        check("R9 load ignored running", 32'(tx_ptr), 32'h2345);

        // R5 receive half page does not stop
        tx_en = 0;
        load(1, 16'h07FF);
        rx_en = 1; rx_byte = 1; cycle(); idle();
        check("R5 rx ptr", 32'(rx_ptr), 32'h0800);
        check("R5 half bit", 32'(status), 32'h2);
        check("R5 still running", 32'(rx_run), 1);

        // R6 receive page sets both and stops
        rx_en = 0;
        load(1, 16'h0FFF);
        rx_en = 1; rx_byte = 1; cycle(); idle();
        check("R6 rx ptr", 32'(rx_ptr), 32'h1000);
        check("R6 both bits", 32'(status), 32'h3);
        check("R6 stopped", 32'(rx_run), 0);

        // R8 set beats clear in the same cycle
        load(1, 16'h17FF);
        wr(4'h0, 4'h1);
        idle(); rx_byte = 1; wr_en = 1; wr_data = 4'h0; wr_mask = 4'h2;
        cycle(); idle();
        check("R8 set wins", 32'(status), 32'h2);

        // R10 mask gating
        irq_mask = 4'hD; cycle();
        check("R10 masked off", 32'(irq), 0);
        irq_mask = 4'h2; cycle();
        check("R10 masked on", 32'(irq), 1);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            tx_en   = ($urandom % 8) != 0;
            rx_en   = ($urandom % 8) != 0;
            tx_byte = $urandom % 2;
            rx_byte = $urandom % 2;
            tx_err  = (($urandom % 40) == 0) ? 3'(1 << ($urandom % 3)) : 3'b0;
            ld      = ($urandom % 6) == 0;
            ld_sel  = $urandom % 2;
            ld_val  = near_edge();
            wr_en   = ($urandom % 5) == 0;
            wr_data = 4'($urandom);
            wr_mask = 4'($urandom);
            if (($urandom % 50) == 0) irq_mask = 4'($urandom);
            cycle();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule